// File: doc/BRIEF.md
# Product Term Sharing Array

This block sits between the AND array of a programmable logic block and its 32 macrocells. The AND array delivers a flat vector of product terms. Every macrocell input has a local cluster of five terms at a fixed position in that vector. A further five terms at the top of the vector are kept apart as shared block controls. Each macrocell input gets one OR sum, built one of two ways. The shared path can gather whole clusters from neighbouring outputs, up to seven clusters or 35 terms for one function. The bypass path uses only the output's own cluster and has a shorter logic path.

Steering is static. A small write port loads one configuration word per output into registers. Those registers take effect on the cycle after the write. A cluster can be lent to only one neighbour. Once lent, it is removed from its home output's sum. When two outputs try to borrow the same cluster, an error flag is raised and that cluster feeds no output. The sum and control outputs are combinational from the term vector and the configuration registers.

Top module: `term_share_array`

## Requirements
- R1: Output o owns the local cluster at terms[5o+4:5o]. After reset every output is in shared mode with both reaches zero, so sumOut[o] is the OR of its own cluster only.
- R2: A configuration word written with cfgWrEn high to address cfgAddr is captured at the rising clock edge. The sums reflect it from that edge on and not before. The word layout is: bit 0 bypass, bits 2:1 reach toward lower-numbered outputs, bits 4:3 reach toward higher-numbered outputs.
- R3: An output in shared mode with reaches lo and hi sums the clusters of outputs o-lo through o+hi. Indices outside 0..31 are dropped. This allows at most seven clusters (35 terms).
- R4: A cluster claimed by any other output is removed from the sum of its home output, whether the home output is in shared or bypass mode.
- R5: An output in bypass mode sums only its own cluster. Its reach fields are ignored and it claims no neighbouring cluster.
- R6: When two or more outputs claim the same cluster, cfgError is 1 and that cluster contributes to no output. In every other case cfgError is 0 and each cluster feeds at most one output.
- R7: ctrlOut equals terms[164:160], in the order set (bit 0), reset, clock, clock enable, output enable (bit 4), under any configuration.
- R8: Asserting rstN low returns all configuration registers to the reset state of R1.
- R9: With all product terms zero, every sum output is zero under any configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rstN | input | 1 | Active-low synchronous reset of the configuration |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 5 | Output whose configuration word is written |
| cfgData | input | 5 | Configuration word: bypass, lower reach, upper reach |
| terms | input | 165 | Product terms: 32 clusters of five, then five control terms |
| sumOut | output | 32 | One OR sum per macrocell |
| ctrlOut | output | 5 | Shared control terms |
| cfgError | output | 1 | A cluster is claimed by more than one output |

## Verification
The assertions assume that rstN is low for at least one rising edge before any check applies. They also assume cfgAddr and cfgData are known whenever cfgWrEn is high, and that terms carries no X or Z values. The stimulus holds reset for several cycles first. It drives every input from a defined value at time zero and changes inputs only on the falling clock edge. Configuration words are applied one per cycle, and each one is recorded in a shadow copy that the reference model uses.

// File: rtl/term_share_pkg.sv
package term_share_pkg;
  localparam int NUM_OUT   = 32;
  localparam int CLUSTER   = 5;
  localparam int REACH_W   = 2;
  localparam int NUM_CTRL  = 5;
  localparam int MAX_REACH = (1 << REACH_W) - 1;
  localparam int WIN       = 2 * MAX_REACH + 1;
  localparam int CENTER    = MAX_REACH;
  localparam int TERMS     = NUM_OUT * CLUSTER + NUM_CTRL;
  localparam int CFG_W     = 1 + 2 * REACH_W;
  localparam int ADDR_W    = $clog2(NUM_OUT);

  // Strobes from the configuration control to the summing datapath.
  // grant[o][w] lets the cluster at offset (w - CENTER) from output o
  // into that output's sum.
  typedef struct packed {
    logic [NUM_OUT-1:0]          bypass;
    logic [NUM_OUT-1:0][WIN-1:0] grant;
  } steer_t;
endpackage

// File: rtl/term_share_ctrl.sv
module term_share_ctrl
  import term_share_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  output steer_t            steer,
  output logic              cfgError
);
  logic [NUM_OUT-1:0]              bypassQ;
  logic [NUM_OUT-1:0][REACH_W-1:0] loQ;
  logic [NUM_OUT-1:0][REACH_W-1:0] hiQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bypassQ <= '0;
      loQ     <= '0;
      hiQ     <= '0;
    end else if (cfgWrEn) begin
      bypassQ[cfgAddr] <= cfgData[0];
      loQ[cfgAddr]     <= cfgData[REACH_W:1];
      hiQ[cfgAddr]     <= cfgData[2*REACH_W:REACH_W+1];
    end
  end

  // claim[o][w]: output o asks for the cluster at offset w - CENTER.
  logic [NUM_OUT-1:0][WIN-1:0] claim;
  // incoming[c][w]: the claimant at offset w relative to it asks for cluster c.
  logic [NUM_OUT-1:0][WIN-1:0] incoming;
  logic [NUM_OUT-1:0]          lent;
  logic [NUM_OUT-1:0]          conflict;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_claim
    for (genvar w = 0; w < WIN; w++) begin : g_win
      localparam int OFS = w - CENTER;
      localparam int CL  = o + OFS;
      if (OFS == 0 || CL < 0 || CL >= NUM_OUT) begin : g_none
        assign claim[o][w] = 1'b0;
      end else if (OFS < 0) begin : g_low
        assign claim[o][w] = !bypassQ[o] &&
                             (REACH_W'(-OFS) <= loQ[o]);
      end else begin : g_high
        assign claim[o][w] = !bypassQ[o] &&
                             (REACH_W'(OFS) <= hiQ[o]);
      end
    end
  end

  for (genvar c = 0; c < NUM_OUT; c++) begin : g_inc
    for (genvar w = 0; w < WIN; w++) begin : g_win
      localparam int SRC = c - (w - CENTER);
      if (w == CENTER || SRC < 0 || SRC >= NUM_OUT) begin : g_none
        assign incoming[c][w] = 1'b0;
      end else begin : g_src
        assign incoming[c][w] = claim[SRC][w];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_OUT; c++) begin
      lent[c]     = |incoming[c];
      conflict[c] = ($countones(incoming[c]) > 1);
    end
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_grant
    for (genvar w = 0; w < WIN; w++) begin : g_win
      localparam int CL = o + w - CENTER;
      if (w == CENTER) begin : g_home
        assign steer.grant[o][w] = !lent[o];
      end else if (CL < 0 || CL >= NUM_OUT) begin : g_none
        assign steer.grant[o][w] = 1'b0;
      end else begin : g_borrow
        assign steer.grant[o][w] = claim[o][w] && !conflict[CL];
      end
    end
  end

  assign steer.bypass = bypassQ;
  assign cfgError     = |conflict;
endmodule

// File: rtl/term_share_path.sv
module term_share_path
  import term_share_pkg::*;
(
  input  logic [TERMS-1:0]    terms,
  input  steer_t              steer,
  output logic [NUM_OUT-1:0]  sumOut,
  output logic [NUM_CTRL-1:0] ctrlOut
);
  logic [NUM_OUT-1:0]          clusterOr;
  logic [NUM_OUT-1:0][WIN-1:0] gathered;
  logic [NUM_OUT-1:0]          sharedSum;
  logic [NUM_OUT-1:0]          bypassSum;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_cluster
    assign clusterOr[o] = |terms[o*CLUSTER +: CLUSTER];
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    for (genvar w = 0; w < WIN; w++) begin : g_win
      localparam int CL = o + w - CENTER;
      if (CL < 0 || CL >= NUM_OUT) begin : g_none
        assign gathered[o][w] = 1'b0;
      end else begin : g_take
        assign gathered[o][w] = clusterOr[CL] & steer.grant[o][w];
      end
    end
    assign sharedSum[o] = |gathered[o];
    // short path: own terms gated by the home grant only
    assign bypassSum[o] = (|terms[o*CLUSTER +: CLUSTER]) & steer.grant[o][CENTER];
    assign sumOut[o]    = steer.bypass[o] ? bypassSum[o] : sharedSum[o];
  end

  assign ctrlOut = terms[TERMS-1 -: NUM_CTRL];
endmodule

// File: rtl/term_share_array.sv
module term_share_array
  import term_share_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [CFG_W-1:0]    cfgData,
  input  logic [TERMS-1:0]    terms,
  output logic [NUM_OUT-1:0]  sumOut,
  output logic [NUM_CTRL-1:0] ctrlOut,
  output logic                cfgError
);
  steer_t steer;

  term_share_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .steer    (steer),
    .cfgError (cfgError)
  );

  term_share_path u_path (
    .terms   (terms),
    .steer   (steer),
    .sumOut  (sumOut),
    .ctrlOut (ctrlOut)
  );
endmodule

// File: rtl/term_share_array_chk.sv
module term_share_array_chk
  import term_share_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                cfgWrEn,
  input logic [ADDR_W-1:0]   cfgAddr,
  input logic [CFG_W-1:0]    cfgData,
  input logic [TERMS-1:0]    terms,
  input logic [NUM_OUT-1:0]  sumOut,
  input logic [NUM_CTRL-1:0] ctrlOut,
  input logic                cfgError,
  input steer_t              steer
);
  // R7: control terms leave untouched
  assert_ctrl_passthru_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOut == terms[TERMS-1 -: NUM_CTRL]);

  // R9: no active term, no active sum
  assert_zero_terms_R9: assert property (@(posedge clk) disable iff (!rstN)
    (terms == '0) |-> (sumOut == '0));

  // R2: written bypass bit reaches the datapath strobes after the edge
  assert_cfg_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (steer.bypass[$past(cfgAddr)] == $past(cfgData[0])));

  // R6: each cluster is granted to at most one output
  for (genvar c = 0; c < NUM_OUT; c++) begin : g_owner
    logic [WIN-1:0] takers;
    for (genvar w = 0; w < WIN; w++) begin : g_w
      localparam int DST = c - (w - CENTER);
      if (DST < 0 || DST >= NUM_OUT) begin : g_none
        assign takers[w] = 1'b0;
      end else begin : g_t
        assign takers[w] = steer.grant[DST][w];
      end
    end
    assert_single_owner_R6: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(takers));
  end

  // R5: a bypassed output holds no grant away from its own cluster
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_byp
    logic [WIN-1:0] sideGrants;
    always_comb begin
      sideGrants         = steer.grant[o];
      sideGrants[CENTER] = 1'b0;
    end
    assert_bypass_no_reach_R5: assert property (@(posedge clk) disable iff (!rstN)
      steer.bypass[o] |-> (sideGrants == '0));
  end
endmodule

bind term_share_array term_share_array_chk u_chk (.*);

// File: tb/term_share_array_tb.sv
module term_share_array_tb;
  import term_share_pkg::*;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                cfgWrEn = 1'b0;
  logic [ADDR_W-1:0]   cfgAddr = '0;
  logic [CFG_W-1:0]    cfgData = '0;
  logic [TERMS-1:0]    termsIn = '0;
  logic [NUM_OUT-1:0]  sumOut;
  logic [NUM_CTRL-1:0] ctrlOut;
  logic                cfgError;

  int checks = 0;
  int failures = 0;
  int shBy[NUM_OUT];
  int shLo[NUM_OUT];
  int shHi[NUM_OUT];

  always #10 clk = ~clk;

  term_share_array u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .terms(termsIn), .sumOut(sumOut),
    .ctrlOut(ctrlOut), .cfgError(cfgError)
  );

  task automatic clearShadow();
    for (int i = 0; i < NUM_OUT; i++) begin
      shBy[i] = 0; shLo[i] = 0; shHi[i] = 0;
    end
  endtask

  // Reference: count claimants of every cluster, then route it to its owner.
  task automatic modelEval(output logic [NUM_OUT-1:0] s, output logic e);
    int cnt[NUM_OUT];
    int who[NUM_OUT];
    s = '0; e = 1'b0;
    for (int c = 0; c < NUM_OUT; c++) begin cnt[c] = 0; who[c] = c; end
    for (int j = 0; j < NUM_OUT; j++) begin
      if (shBy[j] == 0) begin
        for (int c = j - shLo[j]; c <= j + shHi[j]; c++) begin
          if (c >= 0 && c < NUM_OUT && c != j) begin
            cnt[c]++; who[c] = j;
          end
        end
      end
    end
    for (int c = 0; c < NUM_OUT; c++) begin
      if (cnt[c] > 1) e = 1'b1;
      else if (|termsIn[c*CLUSTER +: CLUSTER]) s[who[c]] = 1'b1;
    end
  endtask

  task automatic check(string req);
    logic [NUM_OUT-1:0] es;
    logic ee;
    modelEval(es, ee);
    checks++;
    if (sumOut !== es) begin
      failures++;
      $display("FAIL %s sumOut actual=%h expected=%h", req, sumOut, es);
    end
    checks++;
    if (cfgError !== ee) begin
      failures++;
      $display("FAIL %s cfgError actual=%b expected=%b", req, cfgError, ee);
    end
    checks++;
    if (ctrlOut !== termsIn[TERMS-1 -: NUM_CTRL]) begin
      failures++;
      $display("FAIL %s ctrlOut actual=%h expected=%h", req, ctrlOut,
               termsIn[TERMS-1 -: NUM_CTRL]);
    end
  endtask

  task automatic checkBit(string req, int idx, logic exp);
    checks++;
    if (sumOut[idx] !== exp) begin
      failures++;
      $display("FAIL %s sumOut[%0d] actual=%b expected=%b", req, idx, sumOut[idx], exp);
    end
  endtask

  task automatic writeCfg(int addr, int by, int lo, int hi);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgAddr = ADDR_W'(addr);
    cfgData = {REACH_W'(hi), REACH_W'(lo), 1'(by)};
    @(negedge clk);
    cfgWrEn = 1'b0;
    shBy[addr] = by; shLo[addr] = lo; shHi[addr] = hi;
  endtask

  task automatic setTerms(logic [TERMS-1:0] v);
    termsIn = v;
    #2;
  endtask

  function automatic logic [TERMS-1:0] oneCluster(int c, int k);
    logic [TERMS-1:0] v = '0;
    v[c*CLUSTER + k] = 1'b1;
    return v;
  endfunction

  function automatic logic [TERMS-1:0] randTerms();
    logic [TERMS-1:0] v;
    for (int i = 0; i < TERMS; i++) v[i] = 1'($urandom_range(0, 3) == 0);
    return v;
  endfunction

  task automatic clearAll();
    for (int i = 0; i < NUM_OUT; i++) writeCfg(i, 0, 0, 0);
  endtask

  task automatic testReset();
    setTerms('0);
    check("R9 zero terms after reset");
    for (int c = 0; c < NUM_OUT; c++) begin
      setTerms(oneCluster(c, c % CLUSTER));
      check("R1 own cluster only");
    end
  endtask

  task automatic testWideShare();
    writeCfg(10, 0, 3, 3);
    setTerms(oneCluster(7, 0));
    checkBit("R3 lowest reach", 10, 1'b1);
    checkBit("R4 lent home masked", 7, 1'b0);
    setTerms(oneCluster(13, 4));
    checkBit("R3 highest reach", 10, 1'b1);
    setTerms(oneCluster(14, 2));
    checkBit("R3 beyond reach", 10, 1'b0);
    checkBit("R3 beyond reach home", 14, 1'b1);
    setTerms(oneCluster(6, 1));
    check("R3 seven clusters");
    writeCfg(0, 0, 3, 0);
    setTerms(oneCluster(31, 0));
    check("R3 clip at low edge");
    writeCfg(31, 0, 0, 3);
    setTerms(oneCluster(1, 3) | oneCluster(30, 0));
    check("R3 clip at high edge");
    clearAll();
  endtask

  task automatic testBypass();
    writeCfg(5, 1, 3, 3);
    setTerms(oneCluster(4, 0) | oneCluster(6, 0));
    checkBit("R5 bypass no reach low", 4, 1'b1);
    checkBit("R5 bypass no reach high", 6, 1'b1);
    checkBit("R5 bypass ignores neighbours", 5, 1'b0);
    setTerms(oneCluster(5, 4));
    checkBit("R5 bypass own cluster", 5, 1'b1);
    writeCfg(4, 0, 0, 1);
    setTerms(oneCluster(5, 2));
    checkBit("R4 bypass home lent", 5, 1'b0);
    checkBit("R4 borrower gets bypass cluster", 4, 1'b1);
    check("R4 lent bypass cluster");
    clearAll();
  endtask

  task automatic testConflict();
    writeCfg(18, 0, 0, 2);
    writeCfg(22, 0, 2, 0);
    setTerms(oneCluster(20, 0));
    checks++;
    if (cfgError !== 1'b1) begin
      failures++;
      $display("FAIL R6 cfgError actual=%b expected=1", cfgError);
    end
    checkBit("R6 conflict masked 18", 18, 1'b0);
    checkBit("R6 conflict masked 20", 20, 1'b0);
    checkBit("R6 conflict masked 22", 22, 1'b0);
    setTerms(oneCluster(19, 0) | oneCluster(21, 0));
    check("R6 single claims still route");
    clearAll();
    check("R6 error clears");
  endtask

  task automatic testLatency();
    @(negedge clk);
    termsIn = oneCluster(6, 0);
    cfgWrEn = 1'b1;
    cfgAddr = ADDR_W'(5);
    cfgData = {REACH_W'(1), REACH_W'(0), 1'b0};
    #2;
    checkBit("R2 not before edge 6", 6, 1'b1);
    checkBit("R2 not before edge 5", 5, 1'b0);
    @(negedge clk);
    cfgWrEn = 1'b0;
    shHi[5] = 1;
    #2;
    checkBit("R2 after edge 6", 6, 1'b0);
    checkBit("R2 after edge 5", 5, 1'b1);
    clearAll();
  endtask

  task automatic testCtrl();
    writeCfg(31, 1, 0, 0);
    writeCfg(30, 0, 0, 3);
    for (int k = 0; k < NUM_CTRL; k++) begin
      logic [TERMS-1:0] v = '0;
      v[NUM_OUT*CLUSTER + k] = 1'b1;
      setTerms(v);
      check("R7 control term alone");
      checks++;
      if (sumOut !== '0) begin
        failures++;
        $display("FAIL R7 sumOut actual=%h expected=0", sumOut);
      end
    end
    clearAll();
  endtask

  task automatic testRandom();
    for (int n = 0; n < 150; n++) begin
      writeCfg($urandom_range(0, NUM_OUT-1), ($urandom_range(0, 3) == 0) ? 1 : 0,
               $urandom_range(0, MAX_REACH), $urandom_range(0, MAX_REACH));
      setTerms(randTerms());
      check("R3 R4 R5 R6 random");
      setTerms('0);
      check("R9 zero terms random config");
    end
  endtask

  task automatic testResetClears();
    writeCfg(3, 0, 3, 3);
    writeCfg(9, 1, 0, 0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    clearShadow();
    for (int c = 0; c < NUM_OUT; c++) begin
      setTerms(oneCluster(c, 1));
      check("R8 reset restores defaults");
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clearShadow();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWideShare();
    testBypass();
    testConflict();
    testLatency();
    testCtrl();
    testRandom();
    testResetClears();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule